// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block sits beside a processor core and decides, at each instruction boundary, whether the core must enter an exception. It latches three kinds of request: a reset request, a non-maskable request, and a 3-bit encoded maskable level from an external priority encoder. The maskable level is compared against the core's status word. When an entry is taken, the block presents a full state update in one bundle, valid for one cycle:
- two stack write requests: the return PC and the old status word;
- the new stack pointer;
- the new status word;
- the handler PC.

Handler addresses for maskable levels come from seven 16-bit vector registers. These are programmed over a small 16-bit register bus that also exposes two constant read-only words. A level entry also drives an acknowledge that carries the delivered level back to the encoder. The level request is not consumed by delivery. It stays until the encoder drives a new value, and the raised mask in the new status word is what stops it from re-entering.

Top module: `irq_entry_seq`

## Requirements
- R1: After rst_ni is released, no update is presented, all vector registers read 0, no request is pending, and the latched level is 7 (no request).
- R2: At a boundary the entry kind is chosen with priority reset, then non-maskable, then level. upd_kind_o encodes 1 = reset, 2 = non-maskable, 3 = level and 0 = none.
- R3: A level L is taken only when the interrupt-enable bit (psw bit 11) is 1 and L is strictly below the mask field (psw bits 10:8). Level 7 is never taken.
- R4: On a non-maskable or level entry, the PC is pushed as a 32-bit word at SP-4, the status word as 16 bits at SP-8, and the new SP is SP-8.
- R5: Every non-maskable or level entry clears the enable bit in the new status word. A level entry also writes the delivered level into the mask field, and all other bits are kept.
- R6: A non-maskable entry sets the new PC to 0x40000008. A level entry sets it to 0x40000000 plus the zero-extended vector register of that level.
- R7: A pending non-maskable request clears when it is taken, and a new request in the same cycle keeps it pending. A level request is not cleared by delivery, so it is taken again at the next boundary if the status word allows.
- R8: ack_valid_o pulses together with upd_valid_o only on level entries, and ack_lvl_o carries the delivered level.
- R9: Register bus: the vector for level i sits at byte offset 4*i (0x00 to 0x18). Offset 0x20 reads the memory-control constant (default 0x0003) and 0x40 reads the mode constant (default 0x0010). Every other offset reads 0. Writes change only the vector registers. Read data is combinational, with the low byte in bits 7:0.
- R10: A reset entry clears the non-maskable pending flag, all vector registers and the latched level (to 7). Requests and writes in that same cycle are dropped.
- R11: Entries are evaluated only when boundary_i is 1, using requests latched on earlier edges. The update appears in the cycle after the boundary edge and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reset_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| lvl_valid_i | input | 1 | Strobe: lvl_i carries a new level |
| lvl_i | input | 3 | Encoded maskable level, 7 = none |
| boundary_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 32 | Current program counter |
| sp_i | input | 32 | Current stack pointer |
| psw_i | input | 16 | Current status word |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| upd_valid_o | output | 1 | State update valid pulse |
| upd_kind_o | output | 2 | Entry kind of the update |
| push_pc_addr_o | output | 32 | Word push address |
| push_pc_data_o | output | 32 | Word push data (return PC) |
| push_psw_addr_o | output | 32 | Half push address |
| push_psw_data_o | output | 16 | Half push data (old status word) |
| new_sp_o | output | 32 | New stack pointer |
| new_psw_o | output | 16 | New status word |
| new_pc_o | output | 32 | Handler PC |
| ack_valid_o | output | 1 | Level acknowledge pulse |
| ack_lvl_o | output | 3 | Delivered level |

## Verification
The bench targets several corner cases, each tied to the failure it would expose:
- A level exactly equal to the mask. A design with a less-or-equal compare would take it.
- Level 7 under a fully open mask. A design that does not treat 7 as "none" would enter.
- A non-maskable request arriving on the same edge as a boundary. A design that arbitrates on the raw input would jump the queue.
- Back-to-back boundaries with the level held. A design that consumes the level on delivery would lose the second entry.
- A non-maskable request that is not re-raised. A design that keeps its pending flag would enter twice.
- A reset entry followed by vector reads and an open-mask boundary. A design that misses part of the clear would show stale vectors or a stale level.
- Writes to the read-only and unmapped offsets. A design with loose decoding would alias them onto vectors.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_RESET = 2'd1,
    ENT_NMI   = 2'd2,
    ENT_LEVEL = 2'd3
  } entry_e;

  typedef struct packed {
    logic [WORD_W-1:0] pc_addr;
    logic [WORD_W-1:0] pc_data;
    logic [WORD_W-1:0] psw_addr;
    logic [HALF_W-1:0] psw_data;
    logic [WORD_W-1:0] sp;
    logic [HALF_W-1:0] psw;
    logic [WORD_W-1:0] pc;
  } upd_t;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_entry_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned NONE_LVL = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reset_req_i,
  input  logic             nmi_req_i,
  input  logic             lvl_valid_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  entry_e           take_i,
  output logic             rst_pend_o,
  output logic             nmi_pend_o,
  output logic [LVL_W-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pend_o <= 1'b0;
      nmi_pend_o <= 1'b0;
      lvl_o      <= LVL_W'(NONE_LVL);
    end else if (take_i == ENT_RESET) begin
      // reset entry wins over everything arriving in the same cycle
      rst_pend_o <= 1'b0;
      nmi_pend_o <= 1'b0;
      lvl_o      <= LVL_W'(NONE_LVL);
    end else begin
      if (reset_req_i) rst_pend_o <= 1'b1;
      if (nmi_req_i)                nmi_pend_o <= 1'b1;
      else if (take_i == ENT_NMI)   nmi_pend_o <= 1'b0;
      if (lvl_valid_i) lvl_o <= lvl_i;
    end
  end
endmodule

// File: rtl/irq_vec_regs.sv
module irq_vec_regs #(
  parameter int unsigned NUM_VEC     = 7,
  parameter int unsigned LVL_W       = 3,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned VEC_STRIDE  = 4,
  parameter int unsigned MEMCTL_OFS  = 'h20,
  parameter int unsigned MODE_OFS    = 'h40,
  parameter logic [DATA_W-1:0] MEMCTL_VAL = 16'h0003,
  parameter logic [DATA_W-1:0] MODE_VAL   = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [LVL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] vec_o
);
  logic [DATA_W-1:0] vec_q [NUM_VEC];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_vec
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(i * VEC_STRIDE);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       vec_q[i] <= '0;
      else if (clear_i)                  vec_q[i] <= '0;
      else if (wr_i && addr_i == OFS)    vec_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(MEMCTL_OFS)) rdata_o = MEMCTL_VAL;
    if (addr_i == ADDR_W'(MODE_OFS))   rdata_o = MODE_VAL;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (addr_i == ADDR_W'(i * VEC_STRIDE)) rdata_o = vec_q[i];
    end
  end

  always_comb begin
    vec_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (sel_i == LVL_W'(i)) vec_o = vec_q[i];
    end
  end
endmodule

// File: rtl/irq_entry_arb.sv
module irq_entry_arb
  import irq_entry_pkg::*;
#(
  parameter int unsigned LVL_W    = 3,
  parameter int unsigned IE_BIT   = 11,
  parameter int unsigned LM_LSB   = 8,
  parameter logic [WORD_W-1:0] NMI_PC   = 32'h4000_0008,
  parameter logic [WORD_W-1:0] VEC_BASE = 32'h4000_0000
) (
  input  logic              boundary_i,
  input  logic              rst_pend_i,
  input  logic              nmi_pend_i,
  input  logic [LVL_W-1:0]  lvl_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [HALF_W-1:0] psw_i,
  input  logic [HALF_W-1:0] vec_i,
  output entry_e            kind_o,
  output upd_t              upd_o
);
  localparam logic [WORD_W-1:0] WORD_BYTES = WORD_W / 8;
  localparam logic [WORD_W-1:0] FRAME      = 2 * WORD_BYTES;

  logic [LVL_W-1:0] mask_lvl;
  logic             ie;

  always_comb begin
    mask_lvl = psw_i[LM_LSB +: LVL_W];
    ie       = psw_i[IE_BIT];
    kind_o   = ENT_NONE;
    upd_o    = '0;
    if (boundary_i) begin
      if (rst_pend_i)                   kind_o = ENT_RESET;
      else if (nmi_pend_i)              kind_o = ENT_NMI;
      else if (ie && lvl_i < mask_lvl)  kind_o = ENT_LEVEL;
    end
    if (kind_o == ENT_NMI || kind_o == ENT_LEVEL) begin
      upd_o.pc_addr      = sp_i - WORD_BYTES;
      upd_o.pc_data      = pc_i;
      upd_o.psw_addr     = sp_i - FRAME;
      upd_o.psw_data     = psw_i;
      upd_o.sp           = sp_i - FRAME;
      upd_o.psw          = psw_i;
      upd_o.psw[IE_BIT]  = 1'b0;
      if (kind_o == ENT_LEVEL) begin
        upd_o.psw[LM_LSB +: LVL_W] = lvl_i;
        upd_o.pc = VEC_BASE + {{(WORD_W-HALF_W){1'b0}}, vec_i};
      end else begin
        upd_o.pc = NMI_PC;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_VEC    = 7,
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned IE_BIT     = 11,
  parameter int unsigned LM_LSB     = 8,
  parameter logic [31:0] NMI_PC     = 32'h4000_0008,
  parameter logic [31:0] VEC_BASE   = 32'h4000_0000,
  parameter logic [15:0] MEMCTL_VAL = 16'h0003,
  parameter logic [15:0] MODE_VAL   = 16'h0010
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reset_req_i,
  input  logic              nmi_req_i,
  input  logic              lvl_valid_i,
  input  logic [2:0]        lvl_i,
  input  logic              boundary_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       sp_i,
  input  logic [15:0]       psw_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              upd_valid_o,
  output logic [1:0]        upd_kind_o,
  output logic [31:0]       push_pc_addr_o,
  output logic [31:0]       push_pc_data_o,
  output logic [31:0]       push_psw_addr_o,
  output logic [15:0]       push_psw_data_o,
  output logic [31:0]       new_sp_o,
  output logic [15:0]       new_psw_o,
  output logic [31:0]       new_pc_o,
  output logic              ack_valid_o,
  output logic [2:0]        ack_lvl_o
);
  localparam int unsigned LVL_W = $clog2(NUM_VEC + 1);

  logic             rst_pend, nmi_pend;
  logic [LVL_W-1:0] lvl_q;
  logic [15:0]      vec_sel;
  entry_e           kind_d, kind_q;
  upd_t             upd_d, upd_q;
  logic [LVL_W-1:0] ack_lvl_q;

  irq_req_latch #(.LVL_W(LVL_W), .NONE_LVL(NUM_VEC)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reset_req_i (reset_req_i),
    .nmi_req_i   (nmi_req_i),
    .lvl_valid_i (lvl_valid_i),
    .lvl_i       (LVL_W'(lvl_i)),
    .take_i      (kind_d),
    .rst_pend_o  (rst_pend),
    .nmi_pend_o  (nmi_pend),
    .lvl_o       (lvl_q)
  );

  irq_vec_regs #(
    .NUM_VEC(NUM_VEC), .LVL_W(LVL_W), .ADDR_W(ADDR_W), .DATA_W(16),
    .MEMCTL_VAL(MEMCTL_VAL), .MODE_VAL(MODE_VAL)
  ) u_vec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (kind_d == ENT_RESET),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .sel_i   (lvl_q),
    .vec_o   (vec_sel)
  );

  irq_entry_arb #(
    .LVL_W(LVL_W), .IE_BIT(IE_BIT), .LM_LSB(LM_LSB),
    .NMI_PC(NMI_PC), .VEC_BASE(VEC_BASE)
  ) u_arb (
    .boundary_i (boundary_i),
    .rst_pend_i (rst_pend),
    .nmi_pend_i (nmi_pend),
    .lvl_i      (lvl_q),
    .pc_i       (pc_i),
    .sp_i       (sp_i),
    .psw_i      (psw_i),
    .vec_i      (vec_sel),
    .kind_o     (kind_d),
    .upd_o      (upd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q    <= ENT_NONE;
      upd_q     <= '0;
      ack_lvl_q <= '0;
    end else begin
      kind_q    <= kind_d;
      upd_q     <= upd_d;
      ack_lvl_q <= (kind_d == ENT_LEVEL) ? lvl_q : '0;
    end
  end

  assign upd_valid_o     = kind_q != ENT_NONE;
  assign upd_kind_o      = kind_q;
  assign push_pc_addr_o  = upd_q.pc_addr;
  assign push_pc_data_o  = upd_q.pc_data;
  assign push_psw_addr_o = upd_q.psw_addr;
  assign push_psw_data_o = upd_q.psw_data;
  assign new_sp_o        = upd_q.sp;
  assign new_psw_o       = upd_q.psw;
  assign new_pc_o        = upd_q.pc;
  assign ack_valid_o     = kind_q == ENT_LEVEL;
  assign ack_lvl_o       = 3'(ack_lvl_q);
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned IE_BIT = 11,
  parameter int unsigned LM_LSB = 8,
  parameter logic [31:0] NMI_PC = 32'h4000_0008
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        boundary_i,
  input logic        upd_valid_o,
  input logic [1:0]  upd_kind_o,
  input logic [31:0] push_pc_addr_o,
  input logic [31:0] push_psw_addr_o,
  input logic [15:0] push_psw_data_o,
  input logic [31:0] new_sp_o,
  input logic [15:0] new_psw_o,
  input logic [31:0] new_pc_o,
  input logic        ack_valid_o,
  input logic [2:0]  ack_lvl_o
);
  // R11: an update only follows a boundary edge
  p_upd_after_boundary_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_o |-> $past(boundary_i));

  // R8: acknowledge only accompanies level updates
  p_ack_level_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (upd_valid_o && upd_kind_o == 2'd3));

  p_frame_layout_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && upd_kind_o[1]) |->
      (new_sp_o == push_psw_addr_o && push_pc_addr_o == push_psw_addr_o + 32'd4));

  p_ie_cleared_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && upd_kind_o[1]) |-> !new_psw_o[IE_BIT]);

  p_level_masked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> (push_psw_data_o[IE_BIT] &&
                     ack_lvl_o < push_psw_data_o[LM_LSB +: 3] &&
                     new_psw_o[LM_LSB +: 3] == ack_lvl_o));

  p_nmi_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_o && upd_kind_o == 2'd2) |-> new_pc_o == NMI_PC);
endmodule

bind irq_entry_seq irq_entry_chk #(.IE_BIT(IE_BIT), .LM_LSB(LM_LSB), .NMI_PC(NMI_PC)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .boundary_i      (boundary_i),
  .upd_valid_o     (upd_valid_o),
  .upd_kind_o      (upd_kind_o),
  .push_pc_addr_o  (push_pc_addr_o),
  .push_psw_addr_o (push_psw_addr_o),
  .push_psw_data_o (push_psw_data_o),
  .new_sp_o        (new_sp_o),
  .new_psw_o       (new_psw_o),
  .new_pc_o        (new_pc_o),
  .ack_valid_o     (ack_valid_o),
  .ack_lvl_o       (ack_lvl_o)
);

// File: tb/sim_irq_entry_seq.sv
`timescale 1ns/1ps
module sim_irq_entry_seq;
  localparam logic [15:0] MEMCTL = 16'h0003;
  localparam logic [15:0] MODE   = 16'h0010;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reset_req_i = 0, nmi_req_i = 0, lvl_valid_i = 0, boundary_i = 0, reg_wr_i = 0;
  logic [2:0] lvl_i = 0;
  logic [31:0] pc_i = 0, sp_i = 0;
  logic [15:0] psw_i = 0, reg_wdata_i = 0;
  logic [6:0] reg_addr_i = 0;
  logic [15:0] reg_rdata_o, push_psw_data_o, new_psw_o;
  logic upd_valid_o, ack_valid_o;
  logic [1:0] upd_kind_o;
  logic [31:0] push_pc_addr_o, push_pc_data_o, push_psw_addr_o, new_sp_o, new_pc_o;
  logic [2:0] ack_lvl_o;

  always #2 clk = ~clk;

  irq_entry_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .reset_req_i(reset_req_i), .nmi_req_i(nmi_req_i),
    .lvl_valid_i(lvl_valid_i), .lvl_i(lvl_i), .boundary_i(boundary_i),
    .pc_i(pc_i), .sp_i(sp_i), .psw_i(psw_i), .reg_wr_i(reg_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .upd_valid_o(upd_valid_o), .upd_kind_o(upd_kind_o),
    .push_pc_addr_o(push_pc_addr_o), .push_pc_data_o(push_pc_data_o),
    .push_psw_addr_o(push_psw_addr_o), .push_psw_data_o(push_psw_data_o),
    .new_sp_o(new_sp_o), .new_psw_o(new_psw_o), .new_pc_o(new_pc_o),
    .ack_valid_o(ack_valid_o), .ack_lvl_o(ack_lvl_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  bit m_rst, m_nmi;
  logic [2:0] m_lvl;
  logic [15:0] m_vec [7];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] m_read(input logic [6:0] a);
    if (a[1:0] == 2'b00 && a <= 7'h18) return m_vec[a >> 2];
    if (a == 7'h20) return MEMCTL;
    if (a == 7'h40) return MODE;
    return 16'h0;
  endfunction

  function automatic logic [1:0] m_kind(input bit bnd, input logic [15:0] psw);
    if (!bnd) return 2'd0;
    if (m_rst) return 2'd1;
    if (m_nmi) return 2'd2;
    if (psw[11] && m_lvl < psw[10:8]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic step(input string tag, input bit rr, input bit nr, input bit lv,
                      input logic [2:0] l, input bit bnd, input logic [31:0] pc,
                      input logic [31:0] sp, input logic [15:0] psw,
                      input bit wr, input logic [6:0] a, input logic [15:0] wd);
    logic [1:0] k;
    logic [15:0] npsw;
    reset_req_i = rr; nmi_req_i = nr; lvl_valid_i = lv; lvl_i = l; boundary_i = bnd;
    pc_i = pc; sp_i = sp; psw_i = psw; reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = wd;
    k = m_kind(bnd, psw);
    @(posedge clk); #1;
    chk({tag, " R11 valid"}, upd_valid_o, k != 2'd0);
    chk({tag, " R2 kind"}, upd_kind_o, k);
    chk({tag, " R8 ack"}, ack_valid_o, k == 2'd3);
    if (k[1]) begin
      npsw = psw; npsw[11] = 1'b0;
      if (k == 2'd3) npsw[10:8] = m_lvl;
      chk({tag, " R4 pcaddr"}, push_pc_addr_o, sp - 32'd4);
      chk({tag, " R4 pcdata"}, push_pc_data_o, pc);
      chk({tag, " R4 pswaddr"}, push_psw_addr_o, sp - 32'd8);
      chk({tag, " R4 pswdata"}, {16'h0, push_psw_data_o}, {16'h0, psw});
      chk({tag, " R4 sp"}, new_sp_o, sp - 32'd8);
      chk({tag, " R5 psw"}, {16'h0, new_psw_o}, {16'h0, npsw});
      chk({tag, " R6 pc"}, new_pc_o,
          (k == 2'd2) ? 32'h4000_0008 : 32'h4000_0000 + {16'h0, m_vec[m_lvl]});
      if (k == 2'd3) chk({tag, " R8 lvl"}, {29'h0, ack_lvl_o}, {29'h0, m_lvl});
    end
    if (k == 2'd1) begin
      m_rst = 0; m_nmi = 0; m_lvl = 3'd7;
      for (int i = 0; i < 7; i++) m_vec[i] = 16'h0;
    end else begin
      if (rr) m_rst = 1;
      if (nr) m_nmi = 1; else if (k == 2'd2) m_nmi = 0;
      if (lv) m_lvl = l;
      if (wr && a[1:0] == 2'b00 && a <= 7'h18) m_vec[a >> 2] = wd;
    end
    @(negedge clk);
  endtask

  task automatic rd(input string tag, input logic [6:0] a);
    reset_req_i = 0; nmi_req_i = 0; lvl_valid_i = 0; boundary_i = 0; reg_wr_i = 0;
    reg_addr_i = a;
    #1;
    chk(tag, {16'h0, reg_rdata_o}, {16'h0, m_read(a)});
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 3'd0, 0, 32'h0, 32'h1000, 16'h0, 0, 7'h0, 16'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    m_rst = 0; m_nmi = 0; m_lvl = 3'd7;
    for (int i = 0; i < 7; i++) m_vec[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 valid after reset", upd_valid_o, 0);
    for (int i = 0; i < 7; i++) rd("R1 vector zero", 7'(i * 4));
    // R9: constants and holes
    rd("R9 memctl", 7'h20);
    rd("R9 mode", 7'h40);
    rd("R9 hole 1c", 7'h1c);
    // R9: program vectors, then attempt writes elsewhere
    for (int i = 0; i < 7; i++)
      step("R9 write", 0, 0, 0, 3'd0, 0, 0, 32'h1000, 0, 1, 7'(i * 4), 16'(16'h100 * (i + 1)));
    step("R9 write ro", 0, 0, 0, 3'd0, 0, 0, 32'h1000, 0, 1, 7'h20, 16'hffff);
    step("R9 write hole", 0, 0, 0, 3'd0, 0, 0, 32'h1000, 0, 1, 7'h02, 16'hbeef);
    rd("R9 ro unchanged", 7'h20);
    rd("R9 vec0 unchanged", 7'h00);
    rd("R9 hole reads 0", 7'h02);
    for (int i = 0; i < 7; i++) rd("R9 vector readback", 7'(i * 4));

    // R3: level 7 (from reset, R1) under open mask is never taken
    step("R3 level7", 0, 0, 0, 3'd0, 1, 32'h100, 32'h2000, 16'h0f00, 0, 0, 0);
    step("R3 set lvl3", 0, 0, 1, 3'd3, 0, 0, 32'h2000, 0, 0, 0, 0);
    step("R3 equal mask", 0, 0, 0, 3'd0, 1, 32'h100, 32'h2000, 16'h0b00, 0, 0, 0);
    step("R3 ie off", 0, 0, 0, 3'd0, 1, 32'h100, 32'h2000, 16'h0400, 0, 0, 0);
    step("R3 taken", 0, 0, 0, 3'd0, 1, 32'h104, 32'h2000, 16'h0c55, 0, 0, 0);
    step("R7 level held", 0, 0, 0, 3'd0, 1, 32'h108, 32'h1ff8, 16'h0c55, 0, 0, 0);
    // R2/R11: nmi on the boundary edge is not yet pending
    step("R11 nmi same edge", 0, 1, 0, 3'd0, 1, 32'h200, 32'h3000, 16'h0f00, 0, 0, 0);
    step("R2 nmi over level", 0, 0, 0, 3'd0, 1, 32'h204, 32'h3000, 16'h0f00, 0, 0, 0);
    step("R7 nmi cleared", 0, 0, 0, 3'd0, 1, 32'h208, 32'h3000, 16'h0f00, 0, 0, 0);
    // R11: no boundary, no entry
    step("R11 nmi pend", 0, 1, 0, 3'd0, 0, 0, 32'h3000, 16'h0f00, 0, 0, 0);
    idle("R11 idle");
    idle("R11 idle");
    step("R11 nmi at boundary", 0, 0, 0, 3'd0, 1, 32'h300, 32'h4000, 16'h0800, 0, 0, 0);
    // R2/R10: reset beats nmi, clears everything
    step("R10 req", 1, 1, 0, 3'd0, 0, 0, 32'h4000, 0, 0, 0, 0);
    step("R2 reset first", 0, 0, 0, 3'd0, 1, 32'h400, 32'h4000, 16'h0f00, 0, 0, 0);
    step("R10 nothing left", 0, 0, 0, 3'd0, 1, 32'h404, 32'h4000, 16'h0f00, 0, 0, 0);
    for (int i = 0; i < 7; i++) rd("R10 vector cleared", 7'(i * 4));

    // random mix
    for (int n = 0; n < 3000; n++) begin
      bit rr, nr, lv, bnd, wr;
      rr  = ($urandom % 100) < 1;
      nr  = ($urandom % 100) < 6;
      lv  = ($urandom % 100) < 12;
      bnd = ($urandom % 100) < 55;
      wr  = ($urandom % 100) < 10;
      step("rand", rr, nr, lv, 3'($urandom), bnd, $urandom, $urandom, 16'($urandom),
           wr, 7'($urandom % 36) & 7'h7c, 16'($urandom));
      if ((n % 8) == 0) rd("R9 rand read", 7'($urandom));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule